// File: doc/BRIEF.md
# Sequential Four-Operand Summer with One Shared Adder

The block adds four 8-bit operands with a single adder that it reuses over three clock cycles in a row, rather than chaining three adders. A one-cycle request on `start_i` takes a copy of all four operand inputs into registers. The ports may carry new values on every cycle afterwards without any effect on the calculation in progress.

Over the next three edges the adder works through the captured values in a fixed order. The first pass adds the first and second operands. The second pass adds the third operand to that partial sum, and the third pass adds the fourth. The final value goes to `sum_o`, and `done_o` pulses for one cycle.

Registers outside an active calculation keep their contents instead of being cleared, so idle logic does not switch. Every register loads only under an enable, so a synthesis flow can turn each enable into a clock gate. A request that arrives while a calculation runs is dropped.

Top module: `quad_sum_seq`

## Requirements
- R1: `sum_o` delivers (a + b + c + d) mod 256. Every carry out of bit 7 is discarded.
- R2: The operands used are the port values on the clock edge where the request is accepted. Port changes after that edge do not affect the result.
- R3: The result appears on `sum_o` after the third rising edge following the accepting edge. `done_o` is high during exactly that one cycle and low again after the next edge.
- R4: `busy_o` rises after the accepting edge and stays high for exactly three cycles. It is low in the cycle where `done_o` is high.
- R5: A request while `busy_o` is high is ignored. The running result is unchanged, and no extra `done_o` pulse follows.
- R6: `sum_o` holds its value between completions, whatever the operand ports and `start_i` do.
- R7: While `rst_ni` is low, `sum_o`, `busy_o` and `done_o` are zero.
- R8: A request in the cycle where `done_o` is high is accepted. Its result follows three cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request for a new calculation |
| op_a_i | input | 8 | First operand |
| op_b_i | input | 8 | Second operand |
| op_c_i | input | 8 | Third operand |
| op_d_i | input | 8 | Fourth operand |
| sum_o | output | 8 | Result, held until the next completion |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives and samples at falling edges and counts rising edges from the accepting edge. `busy_o` must be high at the first three samples after a request. The fourth sample must show the result on `sum_o`, `done_o` high and `busy_o` low. The following sample must show `done_o` low with `sum_o` unchanged. Operands are randomised on every cycle after the request, and the expected value comes from the values present on the request cycle. Extra requests are placed inside the busy window and on the done cycle, to check which requests are dropped and which are accepted.

// File: rtl/qs_pkg.sv
package qs_pkg;
  localparam int NUM_OPS   = 4;
  localparam int NUM_STEPS = NUM_OPS - 1;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
endpackage

// File: rtl/qs_ctrl.sv
module qs_ctrl
  import qs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              capture_o,
  output logic              psum_en_o,
  output logic              sum_en_o,
  output logic [STEP_W-1:0] step_o,
  output logic              busy_o,
  output logic              done_o
);
  logic last;
  assign last      = (step_o == LAST_STEP);
  assign capture_o = start_i && !busy_o;
  assign psum_en_o = busy_o && !last;
  assign sum_en_o  = busy_o && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      step_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= sum_en_o;
      if (capture_o) begin
        busy_o <= 1'b1;
        step_o <= '0;
      end else if (busy_o) begin
        if (last) busy_o <= 1'b0;
        else      step_o <= step_o + 1'b1;
      end
    end
  end

  assert_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && step_o == '0));
  assert_finish_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && last) |=> (done_o && !busy_o));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_ignore_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last && start_i) |=> (busy_o && step_o == $past(step_o) + 1'b1));
endmodule

// File: rtl/qs_operand_bank.sv
module qs_operand_bank
  import qs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          capture_i,
  input  logic                          busy_i,
  input  logic [NUM_OPS-1:0][WIDTH-1:0] ops_i,
  output logic [NUM_OPS-1:0][WIDTH-1:0] ops_q_o
);
  // Enable-only load, no else branch: gating candidate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ops_q_o <= '0;
    else if (capture_i) ops_q_o <= ops_i;
  end

  assert_hold_ops_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ops_q_o));
endmodule

// File: rtl/qs_shared_adder.sv
module qs_shared_adder
  import qs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [STEP_W-1:0]             step_i,
  input  logic [NUM_OPS-1:0][WIDTH-1:0] ops_q_i,
  input  logic [WIDTH-1:0]              psum_i,
  output logic [WIDTH-1:0]              res_o
);
  logic [NUM_STEPS-1:0][WIDTH-1:0] addend;
  logic [WIDTH-1:0] lhs, rhs;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_addend
    assign addend[g] = ops_q_i[g+1];
  end

  assign lhs   = (step_i == '0) ? ops_q_i[0] : psum_i;
  assign rhs   = addend[step_i];
  assign res_o = lhs + rhs;  // carry dropped
endmodule

// File: rtl/quad_sum_seq.sv
module quad_sum_seq
  import qs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [WIDTH-1:0] op_c_i,
  input  logic [WIDTH-1:0] op_d_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             busy_o,
  output logic             done_o
);
  logic                          capture, psum_en, sum_en;
  logic [STEP_W-1:0]             step;
  logic [NUM_OPS-1:0][WIDTH-1:0] ops_in, ops_q;
  logic [WIDTH-1:0]              psum_q, add_res;

  assign ops_in = {op_d_i, op_c_i, op_b_i, op_a_i};

  qs_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .capture_o(capture), .psum_en_o(psum_en), .sum_en_o(sum_en),
    .step_o(step), .busy_o, .done_o
  );

  qs_operand_bank #(.WIDTH(WIDTH)) u_bank (
    .clk_i, .rst_ni, .capture_i(capture), .busy_i(busy_o),
    .ops_i(ops_in), .ops_q_o(ops_q)
  );

  qs_shared_adder #(.WIDTH(WIDTH)) u_add (
    .step_i(step), .ops_q_i(ops_q), .psum_i(psum_q), .res_o(add_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      psum_q <= '0;
    else if (psum_en) psum_q <= add_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_o <= '0;
    else if (sum_en) sum_o <= add_res;
  end

  assert_sum_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(sum_o));
  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/quad_sum_seq_tb.sv
module quad_sum_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] op_a_i = '0, op_b_i = '0, op_c_i = '0, op_d_i = '0;
  logic [7:0] sum_o;
  logic       busy_o, done_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  quad_sum_seq u_dut (.*);

  function automatic logic [7:0] ref_sum(logic [7:0] a, b, c, d);
    logic [9:0] t = 10'(a) + 10'(b) + 10'(c) + 10'(d);
    return t[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic scramble();
    op_a_i = 8'($urandom); op_b_i = 8'($urandom);
    op_c_i = 8'($urandom); op_d_i = 8'($urandom);
  endtask

  // Apply request at current falling edge; return expected result
  task automatic launch(input logic [7:0] a, b, c, d, output logic [7:0] exp);
    start_i = 1'b1;
    op_a_i = a; op_b_i = b; op_c_i = c; op_d_i = d;
    exp = ref_sum(a, b, c, d);
  endtask

  // Walk the three busy cycles; optional extra request in busy window
  task automatic follow(input logic [7:0] exp, input bit poke);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      start_i = poke && (k == 1);
      scramble();
      chk(busy_o == 1'b1, "R4 busy", busy_o, 1);
      chk(done_o == 1'b0, "R3 early done", done_o, 0);
    end
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R3 done", done_o, 1);
    chk(busy_o == 1'b0, "R4 busy low", busy_o, 0);
    chk(sum_o == exp, "R1 R2 sum", sum_o, exp);
  endtask

  task automatic idle_check(input logic [7:0] exp, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      scramble();
      chk(done_o == 1'b0, "R5 R3 no extra done", done_o, 0);
      chk(busy_o == 1'b0, "R5 no extra busy", busy_o, 0);
      chk(sum_o == exp, "R6 hold", sum_o, exp);
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] exp;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk(sum_o == 8'h0, "R7 sum", sum_o, 0);
    chk(busy_o == 1'b0, "R7 busy", busy_o, 0);
    chk(done_o == 1'b0, "R7 done", done_o, 0);
    start_i = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R7 start in reset", busy_o, 0);
    start_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // Directed corners
    launch(8'hFF, 8'hFF, 8'hFF, 8'hFF, exp); follow(exp, 1'b0);
    chk(exp == 8'hFC, "R1 wrap", exp, 8'hFC);
    idle_check(exp, 3);
    @(negedge clk_i);
    launch(8'h00, 8'h00, 8'h00, 8'h00, exp); follow(exp, 1'b0);
    idle_check(exp, 2);
    @(negedge clk_i);
    launch(8'h80, 8'h80, 8'h01, 8'h02, exp); follow(exp, 1'b1);
    idle_check(exp, 4);  // R5: ignored request leaves no trace

    // Random, mixing back-to-back (R8) and gaps
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      launch(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), exp);
      follow(exp, i[0]);
      if (i[1]) begin
        // R8: request on the done cycle
        launch(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), exp);
        follow(exp, 1'b0);
      end
      idle_check(exp, 1 + (i % 3));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule